// File: doc/BRIEF.md
# Dual-Slot Hamming Parity Code Generator

This block sits beside a parallel data port. It watches the bytes that pass through the port in either direction and computes a single-bit-correcting Hamming parity code over each chunk of 2**CHUNK_AW bytes (256 by default). A code is 22 bits wide: 16 line-parity bits that locate a byte and 6 column-parity bits that locate a bit inside that byte. After a start pulse, the block captures the code of the first chunk into slot 1 and the code of the second chunk into slot 2. Each slot raises its own ready flag. Data that arrives after both slots are full does not change them.

The source can present single bytes or 16-bit words. In word mode the block takes two cycles to process one word, one byte per cycle. It holds its ready output low for the second of those cycles. A configuration bit picks whether the low or the high byte of a word is processed first. The codes are captured on the fly and do not stall the stream beyond that word split. Locating and correcting an error from a stored code is left to the consumer.

Top module: `ecc_dual_slot_gen`

## Requirements
- R1: Line parity is made of 8 pairs, one per bit k of the byte's position within its chunk (0 to 255). Bit 2k+1 is the XOR of the parity of every byte whose position has bit k set. Bit 2k is the same over bytes whose position has bit k clear.
- R2: Column parity is made of 3 pairs, one per bit j of a bit index 0 to 7 inside a byte. Bit 2j+1 is the XOR, over the whole chunk, of every data bit whose index has bit j set. Bit 2j is the same over data bits whose index has bit j clear.
- R3: After a start pulse, bytes 0 to 255 form the code stored in slot 1. `slot1_rdy` is low until the clock edge that accepts byte 255 and is high right after that edge.
- R4: Bytes 256 to 511 form the code stored in slot 2. `slot2_rdy` rises right after the edge that accepts byte 511. `slot2_rdy` is never high while `slot1_rdy` is low.
- R5: Bytes after the 512th do not change either slot or either flag until the next start pulse.
- R6: When `word_mode` is 1, every accepted 16-bit word contributes two consecutive bytes. With `swap_bytes`=0, bits 7:0 go first. With `swap_bytes`=1, bits 15:8 go first. When `word_mode` is 0, only bits 7:0 of `in_data` are used.
- R7: When `word_mode` is 0, `in_ready` stays high. When `word_mode` is 1, `in_ready` is low during the cycle after a word is accepted, and high again in the cycle after that.
- R8: A `start` pulse clears the partial code, the byte position, both slots (to zero) and both flags. Any data presented in the same cycle as `start` is discarded.
- R9: A slot reads all-zero while its flag is low. Once set, a flag stays high until the next `start`.
- R10: Cycles with `in_valid` low do not advance the byte position or change the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Synchronous restart of the code generator |
| word_mode | input | 1 | 1: 16-bit words, 0: single bytes |
| swap_bytes | input | 1 | 1: high byte of a word processed first |
| in_valid | input | 1 | Input data valid |
| in_data | input | 2*BYTE_W | Byte in bits 7:0, or a full 16-bit word |
| in_ready | output | 1 | Block can accept input this cycle |
| slot1_line | output | 2*CHUNK_AW | Line parity of the first chunk |
| slot1_col | output | 2*log2(BYTE_W) | Column parity of the first chunk |
| slot1_rdy | output | 1 | Slot 1 holds a valid code |
| slot2_line | output | 2*CHUNK_AW | Line parity of the second chunk |
| slot2_col | output | 2*log2(BYTE_W) | Column parity of the second chunk |
| slot2_rdy | output | 1 | Slot 2 holds a valid code |

## Verification
A byte presented before a rising edge is processed at that edge. The first byte of a word is also processed at its accepting edge, and the second byte one edge later. Each slot and its flag update at the edge that processes the chunk's last byte. The bench drives inputs on the falling edge. It checks a slot flag at the falling edge before that last edge (expecting low) and at the falling edge right after it (expecting high and the computed code). It checks `in_ready` at the falling edge after each word is accepted.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    // Number of result slots filled after each start.
    localparam int NUM_SLOTS = 2;

    // Which slot the next completed chunk goes into.
    typedef enum logic [1:0] {
        PH_FIRST  = 2'd0,
        PH_SECOND = 2'd1,
        PH_FULL   = 2'd2
    } phase_e;

    // Width of the bit index inside a data unit.
    function automatic int idx_width(input int w);
        return $clog2(w);
    endfunction

endpackage

// File: rtl/ecc_byte_feeder.sv
// Turns byte or word input into one byte per cycle for the accumulator.
module ecc_byte_feeder #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                word_mode,
    input  logic                swap_bytes,
    input  logic                in_valid,
    input  logic [2*BYTE_W-1:0] in_data,
    output logic                in_ready,
    output logic                b_valid,
    output logic [BYTE_W-1:0]   b_data
);

    typedef struct packed {
        logic              pend;
        logic [BYTE_W-1:0] pend_byte;
    } feed_t;

    feed_t st_q, st_d;
    logic  accept;
    logic  [BYTE_W-1:0] lo_byte, hi_byte;

    assign lo_byte = in_data[BYTE_W-1:0];
    assign hi_byte = in_data[2*BYTE_W-1:BYTE_W];

    always_comb begin
        st_d     = st_q;
        in_ready = !st_q.pend;
        accept   = in_valid && in_ready;
        b_valid  = 1'b0;
        b_data   = '0;
        if (st_q.pend) begin
            // second half of a word, input is stalled this cycle
            b_valid   = 1'b1;
            b_data    = st_q.pend_byte;
            st_d.pend = 1'b0;
        end else if (accept) begin
            b_valid = 1'b1;
            if (word_mode) begin
                b_data         = swap_bytes ? hi_byte : lo_byte;
                st_d.pend      = 1'b1;
                st_d.pend_byte = swap_bytes ? lo_byte : hi_byte;
            end else begin
                b_data = lo_byte;
            end
        end
        if (start) begin
            st_d    = '0;
            b_valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/ecc_parity_accum.sv
// Accumulates line and column parity over one chunk of bytes.
module ecc_parity_accum #(
    parameter int BYTE_W   = 8,
    parameter int CHUNK_AW = 8
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       start,
    input  logic                                       b_valid,
    input  logic [BYTE_W-1:0]                          b_data,
    output logic                                       chunk_done,
    output logic [2*CHUNK_AW-1:0]                      code_line,
    output logic [2*ecc_pkg::idx_width(BYTE_W)-1:0]    code_col
);

    localparam int IDX_W  = ecc_pkg::idx_width(BYTE_W);
    localparam int LINE_W = 2 * CHUNK_AW;
    localparam int COL_W  = 2 * IDX_W;

    typedef struct packed {
        logic [CHUNK_AW-1:0] pos;
        logic [LINE_W-1:0]   line;
        logic [COL_W-1:0]    col;
    } acc_t;

    acc_t st_q, st_d;
    logic [LINE_W-1:0] line_n;
    logic [COL_W-1:0]  col_n;
    logic              byte_par;

    always_comb begin
        st_d       = st_q;
        chunk_done = 1'b0;
        byte_par   = ^b_data;
        line_n     = st_q.line;
        col_n      = st_q.col;
        for (int k = 0; k < CHUNK_AW; k++) begin
            if (st_q.pos[k]) line_n[2*k+1] = line_n[2*k+1] ^ byte_par;
            else             line_n[2*k]   = line_n[2*k]   ^ byte_par;
        end
        for (int i = 0; i < BYTE_W; i++) begin
            for (int j = 0; j < IDX_W; j++) begin
                if (((i >> j) & 1) == 1) col_n[2*j+1] = col_n[2*j+1] ^ b_data[i];
                else                     col_n[2*j]   = col_n[2*j]   ^ b_data[i];
            end
        end
        if (b_valid) begin
            st_d.pos = st_q.pos + 1'b1;
            if (&st_q.pos) begin
                chunk_done = 1'b1;
                st_d.line  = '0;
                st_d.col   = '0;
            end else begin
                st_d.line = line_n;
                st_d.col  = col_n;
            end
        end
        if (start) begin
            st_d       = '0;
            chunk_done = 1'b0;
        end
        code_line = line_n;
        code_col  = col_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/ecc_slot_bank.sv
// Routes completed codes into the result slots in order, then freezes.
module ecc_slot_bank #(
    parameter int LINE_W = 16,
    parameter int COL_W  = 6
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          start,
    input  logic                                          chunk_done,
    input  logic [LINE_W-1:0]                             code_line,
    input  logic [COL_W-1:0]                              code_col,
    output logic [ecc_pkg::NUM_SLOTS-1:0][LINE_W-1:0]     slot_line,
    output logic [ecc_pkg::NUM_SLOTS-1:0][COL_W-1:0]      slot_col,
    output logic [ecc_pkg::NUM_SLOTS-1:0]                 slot_rdy
);

    import ecc_pkg::*;

    typedef struct packed {
        logic              rdy;
        logic [LINE_W-1:0] line;
        logic [COL_W-1:0]  col;
    } slot_t;

    phase_e ph_q, ph_d;

    always_comb begin
        ph_d = ph_q;
        if (start) begin
            ph_d = PH_FIRST;
        end else if (chunk_done) begin
            case (ph_q)
                PH_FIRST:  ph_d = PH_SECOND;
                PH_SECOND: ph_d = PH_FULL;
                default:   ph_d = PH_FULL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_FIRST;
        else        ph_q <= ph_d;
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        slot_t sl_q, sl_d;

        always_comb begin
            sl_d = sl_q;
            if (start) begin
                sl_d = '0;
            end else if (chunk_done && (ph_q == phase_e'(g))) begin
                sl_d.rdy  = 1'b1;
                sl_d.line = code_line;
                sl_d.col  = code_col;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sl_q <= '0;
            else        sl_q <= sl_d;
        end

        assign slot_line[g] = sl_q.line;
        assign slot_col[g]  = sl_q.col;
        assign slot_rdy[g]  = sl_q.rdy;
    end

endmodule

// File: rtl/ecc_dual_slot_gen.sv
module ecc_dual_slot_gen #(
    parameter int BYTE_W   = 8,
    parameter int CHUNK_AW = 8
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    start,
    input  logic                                    word_mode,
    input  logic                                    swap_bytes,
    input  logic                                    in_valid,
    input  logic [2*BYTE_W-1:0]                     in_data,
    output logic                                    in_ready,
    output logic [2*CHUNK_AW-1:0]                   slot1_line,
    output logic [2*ecc_pkg::idx_width(BYTE_W)-1:0] slot1_col,
    output logic                                    slot1_rdy,
    output logic [2*CHUNK_AW-1:0]                   slot2_line,
    output logic [2*ecc_pkg::idx_width(BYTE_W)-1:0] slot2_col,
    output logic                                    slot2_rdy
);

    localparam int LINE_W = 2 * CHUNK_AW;
    localparam int COL_W  = 2 * ecc_pkg::idx_width(BYTE_W);

    logic                 b_valid;
    logic [BYTE_W-1:0]    b_data;
    logic                 chunk_done;
    logic [LINE_W-1:0]    code_line;
    logic [COL_W-1:0]     code_col;
    logic [ecc_pkg::NUM_SLOTS-1:0][LINE_W-1:0] s_line;
    logic [ecc_pkg::NUM_SLOTS-1:0][COL_W-1:0]  s_col;
    logic [ecc_pkg::NUM_SLOTS-1:0]             s_rdy;

    ecc_byte_feeder #(.BYTE_W(BYTE_W)) i_feed (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .word_mode  (word_mode),
        .swap_bytes (swap_bytes),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .b_valid    (b_valid),
        .b_data     (b_data)
    );

    ecc_parity_accum #(.BYTE_W(BYTE_W), .CHUNK_AW(CHUNK_AW)) i_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .b_valid    (b_valid),
        .b_data     (b_data),
        .chunk_done (chunk_done),
        .code_line  (code_line),
        .code_col   (code_col)
    );

    ecc_slot_bank #(.LINE_W(LINE_W), .COL_W(COL_W)) i_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .chunk_done (chunk_done),
        .code_line  (code_line),
        .code_col   (code_col),
        .slot_line  (s_line),
        .slot_col   (s_col),
        .slot_rdy   (s_rdy)
    );

    assign slot1_line = s_line[0];
    assign slot1_col  = s_col[0];
    assign slot1_rdy  = s_rdy[0];
    assign slot2_line = s_line[1];
    assign slot2_col  = s_col[1];
    assign slot2_rdy  = s_rdy[1];

endmodule

// File: rtl/ecc_dual_slot_gen_chk.sv
module ecc_dual_slot_gen_chk #(
    parameter int BYTE_W   = 8,
    parameter int CHUNK_AW = 8
) (
    input logic                                    clk,
    input logic                                    rst_n,
    input logic                                    start,
    input logic                                    word_mode,
    input logic                                    in_valid,
    input logic                                    in_ready,
    input logic [2*CHUNK_AW-1:0]                   slot1_line,
    input logic [2*ecc_pkg::idx_width(BYTE_W)-1:0] slot1_col,
    input logic                                    slot1_rdy,
    input logic [2*CHUNK_AW-1:0]                   slot2_line,
    input logic [2*ecc_pkg::idx_width(BYTE_W)-1:0] slot2_col,
    input logic                                    slot2_rdy
);

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!slot1_rdy && !slot2_rdy && slot1_line == '0 && slot1_col == '0
                   && slot2_line == '0 && slot2_col == '0)); // R8

    AST_SLOT1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (slot1_rdy && !start) |=> slot1_rdy); // R9

    AST_SLOT2_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (slot2_rdy && !start) |=> slot2_rdy); // R9

    AST_SLOT1_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (slot1_rdy && !start) |=> ($stable(slot1_line) && $stable(slot1_col))); // R5

    AST_SLOT2_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (slot2_rdy && !start) |=> ($stable(slot2_line) && $stable(slot2_col))); // R5

    AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        slot2_rdy |-> slot1_rdy); // R4

    AST_EMPTY_SLOT1: assert property (@(posedge clk) disable iff (!rst_n)
        !slot1_rdy |-> (slot1_line == '0 && slot1_col == '0)); // R9

    AST_EMPTY_SLOT2: assert property (@(posedge clk) disable iff (!rst_n)
        !slot2_rdy |-> (slot2_line == '0 && slot2_col == '0)); // R9

    AST_WORD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (word_mode && in_valid && in_ready && !start) |=> !in_ready); // R7

    AST_STALL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> in_ready); // R7

endmodule

bind ecc_dual_slot_gen ecc_dual_slot_gen_chk #(.BYTE_W(BYTE_W), .CHUNK_AW(CHUNK_AW)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .word_mode  (word_mode),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .slot1_line (slot1_line),
    .slot1_col  (slot1_col),
    .slot1_rdy  (slot1_rdy),
    .slot2_line (slot2_line),
    .slot2_col  (slot2_col),
    .slot2_rdy  (slot2_rdy)
);

// File: tb/test_ecc_dual_slot_gen.sv
module test_ecc_dual_slot_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        word_mode = 1'b0;
    logic        swap_bytes = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_ready;
    logic [15:0] slot1_line, slot2_line;
    logic [5:0]  slot1_col, slot2_col;
    logic        slot1_rdy, slot2_rdy;

    int tests = 0;
    int fails = 0;
    bit finished = 0;
    logic [7:0] strm [0:1023];
    int n_bytes = 0;
    int stall_bad = 0;
    int byte_rdy_bad = 0;
    int seed_dummy;

    ecc_dual_slot_gen i_ecc_dual_slot_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .word_mode(word_mode),
        .swap_bytes(swap_bytes), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .slot1_line(slot1_line), .slot1_col(slot1_col),
        .slot1_rdy(slot1_rdy), .slot2_line(slot2_line), .slot2_col(slot2_col),
        .slot2_rdy(slot2_rdy)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference code over 256 stream bytes starting at base: {line, col}.
    function automatic logic [21:0] ref_code(input int base);
        logic [15:0] ln = '0;
        logic [5:0]  cl = '0;
        logic [7:0]  fold = '0;
        for (int a = 0; a < 256; a++) begin
            logic p;
            fold = fold ^ strm[base+a];
            p = ^strm[base+a];
            for (int k = 0; k < 8; k++)
                if (p) ln[2*k + ((a >> k) & 1)] = ~ln[2*k + ((a >> k) & 1)];
        end
        for (int j = 0; j < 3; j++) begin
            logic [7:0] hi_mask = '0;
            for (int i = 0; i < 8; i++) hi_mask[i] = ((i >> j) & 1) == 1;
            cl[2*j+1] = ^(fold & hi_mask);
            cl[2*j]   = ^(fold & ~hi_mask);
        end
        return {ln, cl};
    endfunction

    task automatic gap_maybe(input bit allow);
        if (allow && ($urandom % 4 == 0)) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = 16'($urandom);
        end
    endtask

    // Drives one byte; it is taken at the next rising edge.
    task automatic put_byte(input logic [7:0] b, input bit gaps);
        logic [15:0] junk;
        gap_maybe(gaps);
        @(negedge clk);
        if (!in_ready) byte_rdy_bad++;
        junk = 16'($urandom);
        in_valid = 1'b1;
        in_data  = {junk[15:8], b};
        strm[n_bytes] = b;
        n_bytes++;
    endtask

    // Drives one word for one cycle, then idles during the stall cycle.
    task automatic put_word(input logic [15:0] w, input bit gaps);
        gap_maybe(gaps);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        strm[n_bytes]   = swap_bytes ? w[15:8] : w[7:0];
        strm[n_bytes+1] = swap_bytes ? w[7:0]  : w[15:8];
        n_bytes += 2;
        @(negedge clk);
        in_valid = 1'b0;
        if (in_ready !== 1'b0) stall_bad++;
    endtask

    task automatic idle_edge();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pulse_start(input bit with_data);
        @(negedge clk);
        start    = 1'b1;
        in_valid = with_data;
        in_data  = 16'hFFFF;
        @(negedge clk);
        start    = 1'b0;
        in_valid = 1'b0;
        n_bytes  = 0;
    endtask

    task automatic check_slots(input string req, input int which);
        logic [21:0] e;
        if (which == 1) begin
            e = ref_code(0);
            check({req, " slot1 line"}, 32'(slot1_line), 32'(e[21:6]));
            check({req, " slot1 col"},  32'(slot1_col),  32'(e[5:0]));
        end else begin
            e = ref_code(256);
            check({req, " slot2 line"}, 32'(slot2_line), 32'(e[21:6]));
            check({req, " slot2 col"},  32'(slot2_col),  32'(e[5:0]));
        end
    endtask

    task automatic word_run(input bit swp);
        pulse_start(1'b0);
        word_mode  = 1'b1;
        swap_bytes = swp;
        stall_bad  = 0;
        for (int w = 0; w < 256; w++) begin
            put_word(16'($urandom), 1'b1);
            if (w == 127) begin
                check("R3 word slot1 flag", 32'(slot1_rdy), 32'd0);
                @(negedge clk);
                check("R3 word slot1 flag", 32'(slot1_rdy), 32'd1);
            end
        end
        @(negedge clk);
        check(swp ? "R6 swap=1 slot2 flag" : "R6 swap=0 slot2 flag", 32'(slot2_rdy), 32'd1);
        check_slots(swp ? "R6 swap=1" : "R6 swap=0", 1);
        check_slots(swp ? "R6 swap=1" : "R6 swap=0", 2);
        check("R7 word stall cycles", 32'(stall_bad), 32'd0);
        word_mode  = 1'b0;
        swap_bytes = 1'b0;
    endtask

    initial begin
        logic [15:0] keep_l1, keep_l2;
        logic [5:0]  keep_c1, keep_c2;
        seed_dummy = $urandom(32'h5EED_0C1A);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset slot1_rdy", 32'(slot1_rdy), 32'd0);
        check("R9 reset slot2_rdy", 32'(slot2_rdy), 32'd0);
        check("R9 reset slot1 code", 32'({slot1_line, slot1_col}), 32'd0);
        check("R7 reset in_ready", 32'(in_ready), 32'd1);

        // Byte mode with random gaps: three chunks' worth and more.
        byte_rdy_bad = 0;
        for (int i = 0; i < 255; i++) put_byte(8'($urandom), 1'b1);
        put_byte(8'($urandom), 1'b1);
        check("R3 slot1 flag before last edge", 32'(slot1_rdy), 32'd0);
        idle_edge();
        check("R3 slot1 flag after last edge", 32'(slot1_rdy), 32'd1);
        check_slots("R3 R10", 1);
        check("R4 slot2 still empty", 32'(slot2_rdy), 32'd0);
        for (int i = 0; i < 255; i++) put_byte(8'($urandom), 1'b1);
        put_byte(8'($urandom), 1'b1);
        check("R4 slot2 flag before last edge", 32'(slot2_rdy), 32'd0);
        idle_edge();
        check("R4 slot2 flag after last edge", 32'(slot2_rdy), 32'd1);
        check_slots("R4", 2);
        keep_l1 = slot1_line; keep_c1 = slot1_col;
        keep_l2 = slot2_line; keep_c2 = slot2_col;
        for (int i = 0; i < 300; i++) put_byte(8'($urandom), 1'b1);
        idle_edge();
        check("R5 slot1 unchanged", 32'({keep_l1, keep_c1}), 32'({slot1_line, slot1_col}));
        check("R5 slot2 unchanged", 32'({keep_l2, keep_c2}), 32'({slot2_line, slot2_col}));
        check("R9 flags held", 32'({slot1_rdy, slot2_rdy}), 32'b11);
        check("R7 byte mode in_ready high", 32'(byte_rdy_bad), 32'd0);

        // Start clears everything.
        pulse_start(1'b0);
        check("R8 flags cleared", 32'({slot1_rdy, slot2_rdy}), 32'b00);
        check("R8 slots cleared", 32'({slot1_line, slot1_col, slot2_line, slot2_col}), 32'd0);

        // Directed single set bit: byte 0xA5 carries 0x20 -> line 9966, col 26.
        for (int i = 0; i < 256; i++) put_byte((i == 8'hA5) ? 8'h20 : 8'h00, 1'b0);
        idle_edge();
        check("R1 single-bit line", 32'(slot1_line), 32'h9966);
        check("R2 single-bit column", 32'(slot1_col), 32'h26);

        // Partial chunk, then start with data present, then fresh chunk.
        pulse_start(1'b0);
        for (int i = 0; i < 100; i++) put_byte(8'($urandom), 1'b1);
        idle_edge();
        pulse_start(1'b1);
        check("R8 mid-chunk start flags", 32'(slot1_rdy), 32'd0);
        for (int i = 0; i < 256; i++) put_byte(8'($urandom), 1'b1);
        idle_edge();
        check("R8 restart slot1 flag", 32'(slot1_rdy), 32'd1);
        check_slots("R8 restart", 1);

        // Word mode in both byte orders.
        word_run(1'b0);
        word_run(1'b1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule